// File: doc/BRIEF.md
# Asynchronous Scratchpad Transfer Unit

This block lets a core start bulk copies between a slow, variable-latency memory port and its local scratchpad without stalling. The core issues a request carrying a direction, a memory word address, a scratchpad word address and a word count. The block returns a transfer identifier in the cycle the request is accepted. The core then keeps computing while the unit moves the words beat by beat in the background.

The memory port uses a valid/ready request channel. Each beat carries a tag. Responses come back on a separate channel in any order and are matched to their beat by that tag. Load beats are written into the scratchpad as their data arrives. Store beats read the scratchpad first and then send the word to memory. A transfer counts as complete when every one of its beats has been answered.

The core learns about finished transfers by polling. Each poll returns at most one finished identifier, oldest completion first. Reporting an identifier returns it to the free pool.

Top module: `async_spm_xfer`

## Requirements
- R1: While fewer than N_IDS transfers are outstanding, `req_ready` is high and `req_id` shows the lowest free identifier. This holds even while the memory port is stalled. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and it is given the `req_id` shown in that cycle.
- R2: When N_IDS transfers are outstanding (accepted and not yet reported by a poll), `req_ready` is low.
- R3: A load (`req_store`=0) with length field L copies L+1 words. Memory word `req_mem_addr`+i goes to scratchpad word `req_spm_addr`+i, for i = 0..L. No other scratchpad word is written.
- R4: A store (`req_store`=1) with length field L copies scratchpad word `req_spm_addr`+i to memory word `req_mem_addr`+i, for i = 0..L. The scratchpad read port returns data one cycle after `spm_re`.
- R5: Once `mem_req_valid` is high, it stays high with unchanged tag, address and direction until a cycle where `mem_req_ready` is high.
- R6: A beat's tag is {identifier, beat index}, with the beat index in the low LEN_W bits. Responses may return in any order and are matched by this tag. Each response carries exactly one tag.
- R7: `poll_rsp` goes high in the cycle after `poll_en`. If any transfer has finished and not yet been reported, `poll_valid` is high and `poll_id` gives the earliest finished one. Completion order is the order in which each transfer's last response arrived, not the identifier order.
- R8: A poll when no unreported transfer is finished gives `poll_rsp` high and `poll_valid` low.
- R9: An identifier reported by a poll is free from the next cycle on and can be issued again.
- R10: After reset, `req_ready` is high, `req_id` is 0, and `mem_req_valid`, `spm_we`, `spm_re` and `poll_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | A free identifier exists |
| req_store | input | 1 | 1 = scratchpad to memory, 0 = memory to scratchpad |
| req_mem_addr | input | MA_W | First memory word address |
| req_spm_addr | input | SA_W | First scratchpad word address |
| req_len | input | LEN_W | Word count minus one |
| req_id | output | IW | Identifier given to the request |
| poll_en | input | 1 | Poll strobe |
| poll_rsp | output | 1 | Poll answer present |
| poll_valid | output | 1 | Poll answer holds a finished identifier |
| poll_id | output | IW | Finished identifier |
| mem_req_valid | output | 1 | Memory beat request present |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_req_write | output | 1 | Beat is a write |
| mem_req_addr | output | MA_W | Beat word address |
| mem_req_wdata | output | DW | Write data |
| mem_req_tag | output | TAG_W | Beat tag {id, beat} |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_tag | input | TAG_W | Tag of the answered beat |
| mem_rsp_rdata | input | DW | Read data for load beats |
| spm_we | output | 1 | Scratchpad write enable |
| spm_waddr | output | SA_W | Scratchpad write address |
| spm_wdata | output | DW | Scratchpad write data |
| spm_re | output | 1 | Scratchpad read enable |
| spm_raddr | output | SA_W | Scratchpad read address |
| spm_rdata | input | DW | Scratchpad read data, one cycle after `spm_re` |

## Verification
Identifier allocation and identifier release can fall on the same clock edge. The bench provokes this by leaving seven transfers finished, then raising `poll_en` and `req_valid` together. The new request must receive the last free identifier, not the one being released. The next request must then receive exactly the identifier that the poll reported. A second scenario holds memory responses back and releases them newest first, so that the poll order has to follow completion order rather than identifier order.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    IS_PICK = 2'd0,
    IS_RD   = 2'd1,
    IS_CAP  = 2'd2,
    IS_SEND = 2'd3
  } issue_st_e;
endpackage

// File: rtl/xfer_id_pool.sv
module xfer_id_pool #(
  parameter  int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  input  logic [IW-1:0] give_id,
  output logic          avail,
  output logic [IW-1:0] next_id
);
  logic [N-1:0] free_q;

  always_comb begin
    next_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_q[i]) next_id = IW'(i);
    end
  end

  assign avail = |free_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '1;
    end else begin
      if (give) free_q[give_id] <= 1'b1;
      if (take) free_q[next_id] <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_done_fifo.sv
module xfer_done_fifo #(
  parameter  int DEPTH = 8,
  parameter  int W     = 3,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         empty,
  output logic [W-1:0] head
);
  logic [W-1:0]  store_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push) store_q[wr_q] <= push_data;
  end

  assign head  = store_q[rd_q];
  assign empty = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/xfer_beat_issuer.sv
module xfer_beat_issuer
  import xfer_pkg::*;
#(
  parameter  int N     = 8,
  parameter  int MA_W  = 32,
  parameter  int SA_W  = 10,
  parameter  int DW    = 32,
  parameter  int LEN_W = 3,
  localparam int IW    = $clog2(N),
  localparam int TAG_W = IW + LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend,
  input  logic             sel_store,
  input  logic [MA_W-1:0]  sel_maddr,
  input  logic [SA_W-1:0]  sel_saddr,
  input  logic [LEN_W-1:0] sel_beat,
  output logic [IW-1:0]    pick_id,
  output logic             take,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [MA_W-1:0]  mem_req_addr,
  output logic [DW-1:0]    mem_req_wdata,
  output logic [TAG_W-1:0] mem_req_tag,
  output logic             spm_re,
  output logic [SA_W-1:0]  spm_raddr,
  input  logic [DW-1:0]    spm_rdata
);
  issue_st_e st_q;

  always_comb begin
    pick_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) pick_id = IW'(i);
    end
  end

  assign take = (st_q == IS_PICK) && (|pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= IS_PICK;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      mem_req_tag   <= '0;
      spm_re        <= 1'b0;
      spm_raddr     <= '0;
    end else begin
      case (st_q)
        IS_PICK: begin
          if (|pend) begin
            mem_req_tag   <= {pick_id, sel_beat};
            mem_req_addr  <= sel_maddr + MA_W'(sel_beat);
            mem_req_write <= sel_store;
            if (sel_store) begin
              spm_re    <= 1'b1;
              spm_raddr <= sel_saddr + SA_W'(sel_beat);
              st_q      <= IS_RD;
            end else begin
              mem_req_valid <= 1'b1;
              st_q          <= IS_SEND;
            end
          end
        end
        IS_RD: begin
          spm_re <= 1'b0;
          st_q   <= IS_CAP;
        end
        IS_CAP: begin
          mem_req_wdata <= spm_rdata;
          mem_req_valid <= 1'b1;
          st_q          <= IS_SEND;
        end
        default: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            st_q          <= IS_PICK;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/async_spm_xfer.sv
module async_spm_xfer #(
  parameter  int N_IDS = 8,
  parameter  int MA_W  = 32,
  parameter  int SA_W  = 10,
  parameter  int DW    = 32,
  parameter  int LEN_W = 3,
  localparam int IW    = $clog2(N_IDS),
  localparam int TAG_W = IW + LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_store,
  input  logic [MA_W-1:0]  req_mem_addr,
  input  logic [SA_W-1:0]  req_spm_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic [IW-1:0]    req_id,
  input  logic             poll_en,
  output logic             poll_rsp,
  output logic             poll_valid,
  output logic [IW-1:0]    poll_id,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [MA_W-1:0]  mem_req_addr,
  output logic [DW-1:0]    mem_req_wdata,
  output logic [TAG_W-1:0] mem_req_tag,
  input  logic             mem_rsp_valid,
  input  logic [TAG_W-1:0] mem_rsp_tag,
  input  logic [DW-1:0]    mem_rsp_rdata,
  output logic             spm_we,
  output logic [SA_W-1:0]  spm_waddr,
  output logic [DW-1:0]    spm_wdata,
  output logic             spm_re,
  output logic [SA_W-1:0]  spm_raddr,
  input  logic [DW-1:0]    spm_rdata
);
  localparam int CW = LEN_W + 1;

  logic [N_IDS-1:0] ent_busy;
  logic [N_IDS-1:0] ent_store;
  logic [MA_W-1:0]  ent_maddr  [N_IDS];
  logic [SA_W-1:0]  ent_saddr  [N_IDS];
  logic [LEN_W-1:0] ent_len    [N_IDS];
  logic [CW-1:0]    ent_issued [N_IDS];
  logic [CW-1:0]    ent_done   [N_IDS];

  logic             pool_avail;
  logic [IW-1:0]    pool_next;
  logic             accept;
  logic [N_IDS-1:0] pend;
  logic [IW-1:0]    pick_id;
  logic             take;
  logic [IW-1:0]    rsp_id;
  logic [LEN_W-1:0] rsp_beat;
  logic             rsp_last;
  logic             fifo_empty;
  logic [IW-1:0]    fifo_head;
  logic             pop;

  assign req_ready = pool_avail;
  assign req_id    = pool_next;
  assign accept    = req_valid && pool_avail;
  assign rsp_id    = mem_rsp_tag[TAG_W-1 -: IW];
  assign rsp_beat  = mem_rsp_tag[LEN_W-1:0];
  assign rsp_last  = mem_rsp_valid && (ent_done[rsp_id] == CW'(ent_len[rsp_id]));
  assign pop       = poll_en && !fifo_empty;

  xfer_id_pool #(.N(N_IDS)) u_pool (
    .clk     (clk),
    .rst     (rst),
    .take    (accept),
    .give    (pop),
    .give_id (fifo_head),
    .avail   (pool_avail),
    .next_id (pool_next)
  );

  xfer_done_fifo #(.DEPTH(N_IDS), .W(IW)) u_done (
    .clk       (clk),
    .rst       (rst),
    .push      (rsp_last),
    .push_data (rsp_id),
    .pop       (pop),
    .empty     (fifo_empty),
    .head      (fifo_head)
  );

  for (genvar g = 0; g < N_IDS; g++) begin : g_pend
    assign pend[g] = ent_busy[g] && (ent_issued[g] != CW'(ent_len[g]) + CW'(1));
  end

  // Request descriptor fields: written on accept only, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_IDS; i++) begin
      if (accept && pool_next == IW'(i)) begin
        ent_store[i] <= req_store;
        ent_maddr[i] <= req_mem_addr;
        ent_saddr[i] <= req_spm_addr;
        ent_len[i]   <= req_len;
      end
    end
  end

  // Per-entry progress counters and occupancy
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_busy <= '0;
      for (int i = 0; i < N_IDS; i++) begin
        ent_issued[i] <= '0;
        ent_done[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < N_IDS; i++) begin
        if (accept && pool_next == IW'(i)) begin
          ent_busy[i]   <= 1'b1;
          ent_issued[i] <= '0;
          ent_done[i]   <= '0;
        end else begin
          if (take && pick_id == IW'(i))        ent_issued[i] <= ent_issued[i] + 1'b1;
          if (mem_rsp_valid && rsp_id == IW'(i)) ent_done[i]   <= ent_done[i] + 1'b1;
          if (pop && fifo_head == IW'(i))       ent_busy[i]   <= 1'b0;
        end
      end
    end
  end

  xfer_beat_issuer #(
    .N(N_IDS), .MA_W(MA_W), .SA_W(SA_W), .DW(DW), .LEN_W(LEN_W)
  ) u_issue (
    .clk           (clk),
    .rst           (rst),
    .pend          (pend),
    .sel_store     (ent_store[pick_id]),
    .sel_maddr     (ent_maddr[pick_id]),
    .sel_saddr     (ent_saddr[pick_id]),
    .sel_beat      (ent_issued[pick_id][LEN_W-1:0]),
    .pick_id       (pick_id),
    .take          (take),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_tag   (mem_req_tag),
    .spm_re        (spm_re),
    .spm_raddr     (spm_raddr),
    .spm_rdata     (spm_rdata)
  );

  // Load data lands in the scratchpad one cycle after its response
  always_ff @(posedge clk) begin
    if (rst) begin
      spm_we    <= 1'b0;
      spm_waddr <= '0;
      spm_wdata <= '0;
    end else begin
      spm_we    <= mem_rsp_valid && !ent_store[rsp_id];
      spm_waddr <= ent_saddr[rsp_id] + SA_W'(rsp_beat);
      spm_wdata <= mem_rsp_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      poll_rsp   <= 1'b0;
      poll_valid <= 1'b0;
      poll_id    <= '0;
    end else begin
      poll_rsp   <= poll_en;
      poll_valid <= pop;
      poll_id    <= pop ? fifo_head : '0;
    end
  end
endmodule

// File: rtl/async_spm_xfer_chk.sv
module async_spm_xfer_chk #(
  parameter  int N_IDS = 8,
  parameter  int MA_W  = 32,
  parameter  int LEN_W = 3,
  localparam int IW    = $clog2(N_IDS),
  localparam int TAG_W = IW + LEN_W,
  localparam int OW    = $clog2(N_IDS + 1) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IW-1:0]    req_id,
  input logic             poll_en,
  input logic             poll_rsp,
  input logic             poll_valid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [MA_W-1:0]  mem_req_addr,
  input logic [TAG_W-1:0] mem_req_tag,
  input logic             mem_rsp_valid,
  input logic             spm_we
);
  logic [OW-1:0] outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= '0;
    else outstanding <= outstanding + OW'(req_valid && req_ready) - OW'(poll_valid);
  end

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (outstanding == OW'(N_IDS)));

  // R1
  id_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready || req_id != $past(req_id)));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_tag)
      && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R7
  poll_reply_chk: assert property (@(posedge clk) disable iff (rst)
    poll_en |=> poll_rsp);

  // R8
  poll_valid_chk: assert property (@(posedge clk) disable iff (rst)
    poll_valid |-> poll_rsp);

  // R3
  spm_src_chk: assert property (@(posedge clk) disable iff (rst)
    spm_we |-> $past(mem_rsp_valid));
endmodule

bind async_spm_xfer async_spm_xfer_chk #(
  .N_IDS(N_IDS), .MA_W(MA_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/async_spm_xfer_tb.sv
module async_spm_xfer_tb;
  localparam int N_IDS = 8;
  localparam int MA_W  = 32;
  localparam int SA_W  = 10;
  localparam int DW    = 32;
  localparam int LEN_W = 3;
  localparam int IW    = 3;
  localparam int TAG_W = IW + LEN_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             req_valid = 1'b0, req_ready, req_store = 1'b0;
  logic [MA_W-1:0]  req_mem_addr = '0;
  logic [SA_W-1:0]  req_spm_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [IW-1:0]    req_id;
  logic             poll_en = 1'b0, poll_rsp, poll_valid;
  logic [IW-1:0]    poll_id;
  logic             mem_req_valid, mem_req_ready, mem_req_write;
  logic [MA_W-1:0]  mem_req_addr;
  logic [DW-1:0]    mem_req_wdata;
  logic [TAG_W-1:0] mem_req_tag;
  logic             mem_rsp_valid;
  logic [TAG_W-1:0] mem_rsp_tag;
  logic [DW-1:0]    mem_rsp_rdata;
  logic             spm_we, spm_re;
  logic [SA_W-1:0]  spm_waddr, spm_raddr;
  logic [DW-1:0]    spm_wdata, spm_rdata;

  async_spm_xfer #(
    .N_IDS(N_IDS), .MA_W(MA_W), .SA_W(SA_W), .DW(DW), .LEN_W(LEN_W)
  ) u_dut (.*);

  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [DW-1:0] mem_init(int a);
    return 32'hA500_0000 + a * 7;
  endfunction
  function automatic logic [DW-1:0] spm_init(int a);
    return 32'h5000_0000 + a;
  endfunction

  // Scratchpad model: synchronous RAM, one-cycle read
  logic [DW-1:0] spm [256];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) spm[i] <= spm_init(i);
      spm_rdata <= '0;
    end else begin
      if (spm_we) spm[spm_waddr[7:0]] <= spm_wdata;
      if (spm_re) spm_rdata <= spm[spm_raddr[7:0]];
    end
  end

  // Memory model: variable latency, responses picked newest-ready first
  logic [DW-1:0]    mem [256];
  logic             sl_v   [16];
  logic [TAG_W-1:0] sl_tag [16];
  logic [DW-1:0]    sl_dat [16];
  int               sl_cnt [16];
  logic [7:0]       lfsr;
  logic             stall = 1'b0, rsp_hold = 1'b0, lat_rand = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] = mem_init(i);
      for (int i = 0; i < 16; i++) sl_v[i] = 1'b0;
      lfsr          = 8'h5b;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_tag   = '0;
      mem_rsp_rdata = '0;
    end else begin
      int pick, fr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rsp_valid = 1'b0;
      for (int i = 0; i < 16; i++) if (sl_v[i] && sl_cnt[i] > 0) sl_cnt[i]--;
      pick = -1;
      if (!rsp_hold)
        for (int i = 0; i < 16; i++) if (sl_v[i] && sl_cnt[i] == 0) pick = i;
      if (pick >= 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_tag   = sl_tag[pick];
        mem_rsp_rdata = sl_dat[pick];
        sl_v[pick]    = 1'b0;
      end
      fr = -1;
      for (int i = 15; i >= 0; i--) if (!sl_v[i]) fr = i;
      mem_req_ready = !stall && (fr >= 0) && (lfsr[0] | lfsr[1]);
      if (mem_req_valid && mem_req_ready) begin
        sl_v[fr]   = 1'b1;
        sl_tag[fr] = mem_req_tag;
        sl_cnt[fr] = lat_rand ? int'(lfsr[4:2]) : 0;
        if (mem_req_write) begin
          mem[mem_req_addr[7:0]] = mem_req_wdata;
          sl_dat[fr] = '0;
        end else begin
          sl_dat[fr] = mem[mem_req_addr[7:0]];
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_issue(input logic st, input int ma, input int sa, input int len,
                          output logic [IW-1:0] id, output logic rdy);
    req_valid    = 1'b1;
    req_store    = st;
    req_mem_addr = MA_W'(ma);
    req_spm_addr = SA_W'(sa);
    req_len      = LEN_W'(len);
    #1;
    id  = req_id;
    rdy = req_ready;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_poll(output logic v, output logic [IW-1:0] id, output logic r);
    poll_en = 1'b1;
    @(negedge clk);
    poll_en = 1'b0;
    v  = poll_valid;
    id = poll_id;
    r  = poll_rsp;
  endtask

  task automatic wait_done(output logic [IW-1:0] id, output logic found);
    logic v, r;
    found = 1'b0;
    id = '0;
    for (int k = 0; k < 300 && !found; k++) begin
      do_poll(v, id, r);
      if (v) found = 1'b1;
    end
  endtask

  task automatic t_reset();
    logic v, r; logic [IW-1:0] id;
    chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
    chk(req_id == '0, "R10 req_id", req_id, 0);
    chk(!mem_req_valid && !spm_we && !spm_re && !poll_valid, "R10 idle outputs",
        {mem_req_valid, spm_we, spm_re, poll_valid}, 0);
    do_poll(v, id, r);
    chk(r == 1'b1, "R8 poll_rsp on empty", r, 1);
    chk(v == 1'b0, "R8 poll_valid on empty", v, 0);
  endtask

  task automatic t_load();
    logic [IW-1:0] id, did; logic rdy, f;
    do_issue(1'b0, 'h40, 'h10, 3, id, rdy);
    chk(rdy && id == 0, "R1 load gets id 0", id, 0);
    wait_done(did, f);
    chk(f && did == id, "R7 load completion id", did, id);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++)
      chk(spm['h10 + i] == mem_init('h40 + i), "R3 load word", spm['h10 + i], mem_init('h40 + i));
    chk(spm['h14] == spm_init('h14), "R3 no write past end", spm['h14], spm_init('h14));
    chk(spm['h0f] == spm_init('h0f), "R3 no write before start", spm['h0f], spm_init('h0f));
  endtask

  task automatic t_store();
    logic [IW-1:0] id, did; logic rdy, f;
    do_issue(1'b1, 'h90, 'h80, 2, id, rdy);
    chk(rdy && id == 0, "R9 reissued id 0", id, 0);
    wait_done(did, f);
    chk(f && did == id, "R7 store completion id", did, id);
    for (int i = 0; i < 3; i++)
      chk(mem['h90 + i] == spm_init('h80 + i), "R4 store word", mem['h90 + i], spm_init('h80 + i));
    chk(mem['h93] == mem_init('h93), "R4 no write past end", mem['h93], mem_init('h93));
  endtask

  task automatic t_order();
    logic [IW-1:0] a, b, p; logic rdy, v, r;
    rsp_hold = 1'b1;
    do_issue(1'b0, 'h20, 'h30, 0, a, rdy);
    do_issue(1'b0, 'h21, 'h31, 0, b, rdy);
    repeat (20) @(negedge clk);
    do_poll(v, p, r);
    chk(r && !v, "R8 nothing done while held", v, 0);
    rsp_hold = 1'b0;
    repeat (10) @(negedge clk);
    do_poll(v, p, r);
    chk(v && p == b, "R7 newest response finishes first", p, b);
    do_poll(v, p, r);
    chk(v && p == a, "R7 older response second", p, a);
    chk(spm['h30] == mem_init('h20) && spm['h31] == mem_init('h21), "R6 tag match",
        spm['h31], mem_init('h21));
  endtask

  task automatic t_full();
    logic [IW-1:0] id, did; logic rdy, f;
    logic [N_IDS-1:0] seen = '0;
    stall = 1'b1;
    for (int k = 0; k < N_IDS; k++) begin
      do_issue(1'b0, 'h50 + k, 'hA0 + k, 0, id, rdy);
      chk(rdy, "R1 ready while memory stalled", rdy, 1);
      chk(id == IW'(k), "R1 lowest free id", id, k);
    end
    #1;
    chk(req_ready == 1'b0, "R2 full table", req_ready, 0);
    stall = 1'b0;
    lat_rand = 1'b1;
    for (int k = 0; k < N_IDS; k++) begin
      wait_done(did, f);
      if (f) seen[did] = 1'b1;
    end
    chk(seen == '1, "R7 every id reported once", seen, 8'hff);
    repeat (2) @(negedge clk);
    for (int k = 0; k < N_IDS; k++)
      chk(spm['hA0 + k] == mem_init('h50 + k), "R3 full-table load", spm['hA0 + k], mem_init('h50 + k));
  endtask

  task automatic t_mixed();
    logic [IW-1:0] a, b, d; logic rdy, f;
    do_issue(1'b0, 'h60, 'hC0, 7, a, rdy);
    do_issue(1'b1, 'hB0, 'h88, 5, b, rdy);
    wait_done(d, f);
    wait_done(d, f);
    chk(f, "R6 both out-of-order transfers finish", f, 1);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++)
      chk(spm['hC0 + i] == mem_init('h60 + i), "R6 out-of-order load", spm['hC0 + i], mem_init('h60 + i));
    for (int i = 0; i < 6; i++)
      chk(mem['hB0 + i] == spm_init('h88 + i), "R6 out-of-order store", mem['hB0 + i], spm_init('h88 + i));
  endtask

  task automatic t_overlap();
    logic [IW-1:0] id, got, nid, did; logic rdy, f, v;
    for (int k = 0; k < N_IDS - 1; k++) do_issue(1'b0, 'h70 + k, 'hD0 + k, 0, id, rdy);
    repeat (150) @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_mem_addr = 'h77; req_spm_addr = 'hD7; req_len = '0;
    poll_en = 1'b1;
    #1;
    got = req_id;
    @(negedge clk);
    req_valid = 1'b0; poll_en = 1'b0;
    v = poll_valid; did = poll_id;
    chk(got == IW'(N_IDS - 1), "R9 same-cycle alloc takes last free id", got, N_IDS - 1);
    chk(v, "R7 same-cycle poll reports", v, 1);
    #1;
    chk(req_ready, "R9 released id makes room", req_ready, 1);
    do_issue(1'b0, 'h78, 'hD8, 0, nid, rdy);
    chk(nid == did, "R9 polled id reissued", nid, did);
    for (int k = 0; k < N_IDS; k++) wait_done(id, f);
    chk(f, "R7 drain after overlap", f, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_store();
    t_order();
    t_full();
    t_mixed();
    t_overlap();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule